// File: doc/BRIEF.md
# Calendar Day, Month and Weekday Counter

This block keeps the calendar part of a clock. It advances once for each single-cycle day tick and holds four pieces of state: a two-digit BCD day of month, a month number from 1 to 12, a weekday index, and a leap-year flag. The day counter starts at 1 and never holds 0. When the day reaches the length of the current month, it returns to 1 and moves the month on by one. The length of a month depends on the month number and on the leap flag. The user sets the leap flag by hand, and it clears itself when December rolls over into January.

Four button pulses let the user set the calendar. Each pulse is one cycle long and already debounced.
- The set-day pulse steps the day without ever moving the month, so an end-of-month wrap made by hand cannot carry.
- The set-month pulse steps the month and leaves the day alone.
- The set-weekday pulse steps the weekday.
- The leap pulse flips the leap flag.

A master-clear input returns the calendar to 1 January, weekday 0, with the leap flag clear. The leap flag is also driven out so that it can light the decimal point of the day units digit.

Top module: `cal_core`

## Requirements
- R1: After the asynchronous reset, the outputs are day 01, month 1, weekday 0 and leap 0.
- R2: Each accepted day tick below the month limit adds one to the day in BCD. The units run 0..9. The step from units 9 sets the units to 0 and adds one to the tens, so 09 goes to 10 and 19 goes to 20.
- R3: A day tick taken when the day is at or above the current month limit loads day 01. In the same edge it advances the month by one. The day output never reads 00.
- R4: The month limit is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 28 with leap 0 and 29 with leap 1.
- R5: Any month advance from 12 gives month 1 and clears the leap flag on the same edge.
- R6: A leap pulse inverts the leap flag, which appears on leap_o one cycle later. If a month advance from 12 happens in the same cycle, the clear wins.
- R7: A set-day pulse steps the day by the same rule as a tick, including the wrap to 01, but never changes the month.
- R8: A set-month pulse advances the month and leaves the day digits unchanged.
- R9: The weekday steps on each accepted day tick and on each set-weekday pulse. It wraps from WEEK_LEN-1 (6 by default) to 0. A set-weekday pulse leaves the day and month unchanged.
- R10: A day tick arriving in the same cycle as any set-day, set-month or set-weekday pulse is ignored. Only the set pulses take effect.
- R11: While master clear is high, the next edge loads day 01, month 1, weekday 0 and leap 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr_i | input | 1 | Synchronous master clear to 1 January |
| day_tick_i | input | 1 | One-cycle pulse, once per day |
| set_day_i | input | 1 | Debounced set-day pulse |
| set_mon_i | input | 1 | Debounced set-month pulse |
| set_wday_i | input | 1 | Debounced set-weekday pulse |
| leap_tgl_i | input | 1 | Debounced leap-toggle pulse |
| day_tens_o | output | 2 | Day of month, tens digit (BCD) |
| day_units_o | output | 4 | Day of month, units digit (BCD) |
| month_o | output | 4 | Month number 1..12 |
| wday_o | output | WDW (3 by default) | Weekday index 0..WEEK_LEN-1 |
| leap_o | output | 1 | Leap flag, drives the day units decimal point |

## Verification
The bench builds the block with its default parameters: a seven-day week and the leap flag enabled. With these values, every month length can be reached by hand setting, including both February lengths, the December-to-January clear of the leap flag, and the 6-to-0 weekday wrap. A reference model of the calendar in the bench follows each step. Directed scenarios aim at the cases that need it: the 09-to-10 carry, a day left above a shorter month's limit after a month set, a tick that collides with set pulses, and a master clear given together with other inputs.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int unsigned MONTHS_PER_YEAR = 12;
   localparam int unsigned MONTH_W         = $clog2(MONTHS_PER_YEAR + 1);
   localparam int unsigned DAY_BIN_W       = 6;

   typedef logic [MONTH_W-1:0]   month_t;
   typedef logic [DAY_BIN_W-1:0] day_bin_t;

   typedef struct packed {
      logic [1:0] tens;
      logic [3:0] units;
   } bcd_day_t;

   localparam bcd_day_t DAY_FIRST = '{tens: 2'd0, units: 4'd1};
   localparam month_t   MONTH_FIRST = month_t'(1);
   localparam month_t   MONTH_LAST  = month_t'(MONTHS_PER_YEAR);

   // number of days in a month, given the leap flag
   function automatic day_bin_t month_len(input month_t m, input logic leap);
      day_bin_t len;
      case (m)
         month_t'(2):                                 len = leap ? day_bin_t'(29) : day_bin_t'(28);
         month_t'(4), month_t'(6), month_t'(9),
         month_t'(11):                                len = day_bin_t'(30);
         default:                                     len = day_bin_t'(31);
      endcase
      return len;
   endfunction

   function automatic day_bin_t bcd_value(input bcd_day_t d);
      return day_bin_t'(d.tens) * day_bin_t'(10) + day_bin_t'(d.units);
   endfunction

endpackage

// File: rtl/cal_day_ctr.sv
module cal_day_ctr
   import cal_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mclr_i,
   input  logic     step_i,
   input  day_bin_t limit_i,
   output bcd_day_t day_o,
   output logic     at_limit_o
);

   bcd_day_t day_q, day_d;
   day_bin_t day_val;

   assign day_val    = bcd_value(day_q);
   assign at_limit_o = (day_val >= limit_i);

   always_comb begin
      day_d = day_q;
      if (mclr_i) begin
         day_d = DAY_FIRST;
      end else if (step_i) begin
         if (at_limit_o) begin
            day_d = DAY_FIRST;
         end else if (day_q.units == 4'd9) begin
            day_d.units = 4'd0;
            day_d.tens  = day_q.tens + 2'd1;
         end else begin
            day_d.units = day_q.units + 4'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) day_q <= DAY_FIRST;
      else        day_q <= day_d;
   end

   assign day_o = day_q;

   p_day_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(day_q.tens == 2'd0 && day_q.units == 4'd0));

   p_units_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      day_q.units <= 4'd9);

   p_tens_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mclr_i && step_i && !at_limit_o && day_q.units == 4'd9)
      |=> (day_q.units == 4'd0 && day_q.tens == $past(day_q.tens) + 2'd1));

   p_wrap_to_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mclr_i && step_i && at_limit_o) |=> (day_q == DAY_FIRST));

   p_clear_day_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_i |=> (day_q == DAY_FIRST));

endmodule

// File: rtl/cal_month_ctr.sv
module cal_month_ctr
   import cal_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mclr_i,
   input  logic     adv_i,
   input  logic     leap_tgl_i,
   output month_t   month_o,
   output logic     leap_o,
   output day_bin_t limit_o
);

   month_t month_q, month_d;
   logic   year_wrap;

   assign year_wrap = adv_i && (month_q == MONTH_LAST);

   always_comb begin
      month_d = month_q;
      if (mclr_i)         month_d = MONTH_FIRST;
      else if (year_wrap) month_d = MONTH_FIRST;
      else if (adv_i)     month_d = month_q + month_t'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) month_q <= MONTH_FIRST;
      else        month_q <= month_d;
   end

   generate
      if (LEAP_EN) begin : g_leap
         logic leap_q, leap_d;

         always_comb begin
            leap_d = leap_q;
            if (mclr_i || year_wrap) leap_d = 1'b0;
            else if (leap_tgl_i)     leap_d = ~leap_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) leap_q <= 1'b0;
            else        leap_q <= leap_d;
         end

         assign leap_o = leap_q;

         p_leap_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (leap_tgl_i && !mclr_i && !year_wrap) |=> (leap_q != $past(leap_q)));

         p_leap_year_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (year_wrap && !mclr_i) |=> !leap_q);
      end else begin : g_no_leap
         logic unused_tgl;
         assign unused_tgl = leap_tgl_i;
         assign leap_o     = 1'b0;
      end
   endgenerate

   assign limit_o = month_len(month_q, leap_o);
   assign month_o = month_q;

   p_month_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (month_q >= MONTH_FIRST) && (month_q <= MONTH_LAST));

   p_year_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (year_wrap && !mclr_i) |=> (month_q == MONTH_FIRST));

   p_month_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !mclr_i && month_q != MONTH_LAST) |=> (month_q == $past(month_q) + month_t'(1)));

endmodule

// File: rtl/cal_wday_ctr.sv
module cal_wday_ctr #(
   parameter int unsigned WEEK_LEN = 7,
   localparam int unsigned WDW     = (WEEK_LEN > 1) ? $clog2(WEEK_LEN) : 1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mclr_i,
   input  logic           step_i,
   output logic [WDW-1:0] wday_o
);

   localparam logic [WDW-1:0] WDAY_LAST = WDW'(WEEK_LEN - 1);

   initial begin
      assert (WEEK_LEN >= 2 && WEEK_LEN <= 8)
         else $error("cal_wday_ctr: WEEK_LEN must lie in 2..8");
   end

   logic [WDW-1:0] wday_q, wday_d;

   always_comb begin
      wday_d = wday_q;
      if (mclr_i)                            wday_d = '0;
      else if (step_i && wday_q == WDAY_LAST) wday_d = '0;
      else if (step_i)                       wday_d = wday_q + WDW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wday_q <= '0;
      else        wday_q <= wday_d;
   end

   assign wday_o = wday_q;

   p_wday_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wday_q <= WDAY_LAST);

   p_wday_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !mclr_i && wday_q == WDAY_LAST) |=> (wday_q == '0));

   p_wday_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_i |=> (wday_q == '0));

endmodule

// File: rtl/cal_core.sv
module cal_core
   import cal_pkg::*;
#(
   parameter int unsigned WEEK_LEN = 7,
   parameter bit          LEAP_EN  = 1'b1,
   localparam int unsigned WDW     = (WEEK_LEN > 1) ? $clog2(WEEK_LEN) : 1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mclr_i,
   input  logic           day_tick_i,
   input  logic           set_day_i,
   input  logic           set_mon_i,
   input  logic           set_wday_i,
   input  logic           leap_tgl_i,
   output logic [1:0]     day_tens_o,
   output logic [3:0]     day_units_o,
   output logic [3:0]     month_o,
   output logic [WDW-1:0] wday_o,
   output logic           leap_o
);

   initial begin
      assert (MONTH_W == 4) else $error("cal_core: month field width mismatch");
   end

   logic     any_set;
   logic     tick_ok;
   logic     day_at_limit;
   logic     month_carry;
   day_bin_t limit;
   bcd_day_t day;
   month_t   month;

   // a hand-set pulse in the same cycle swallows the day tick
   assign any_set     = set_day_i | set_mon_i | set_wday_i;
   assign tick_ok     = day_tick_i & ~any_set;
   // only a real day tick may carry into the month, never a hand-set day
   assign month_carry = tick_ok & day_at_limit;

   cal_day_ctr u_day (
      .clk        (clk),
      .rst_n      (rst_n),
      .mclr_i     (mclr_i),
      .step_i     (set_day_i | tick_ok),
      .limit_i    (limit),
      .day_o      (day),
      .at_limit_o (day_at_limit)
   );

   cal_month_ctr #(.LEAP_EN(LEAP_EN)) u_month (
      .clk        (clk),
      .rst_n      (rst_n),
      .mclr_i     (mclr_i),
      .adv_i      (set_mon_i | month_carry),
      .leap_tgl_i (leap_tgl_i),
      .month_o    (month),
      .leap_o     (leap_o),
      .limit_o    (limit)
   );

   cal_wday_ctr #(.WEEK_LEN(WEEK_LEN)) u_wday (
      .clk    (clk),
      .rst_n  (rst_n),
      .mclr_i (mclr_i),
      .step_i (set_wday_i | tick_ok),
      .wday_o (wday_o)
   );

   assign day_tens_o  = day.tens;
   assign day_units_o = day.units;
   assign month_o     = month;

   p_set_day_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_day_i && !set_mon_i && !mclr_i) |=> (month_o == $past(month_o)));

   p_set_mon_keeps_day_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mon_i && !set_day_i && !mclr_i)
      |=> (day_tens_o == $past(day_tens_o) && day_units_o == $past(day_units_o)));

   p_tick_yields_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (day_tick_i && set_wday_i && !set_day_i && !set_mon_i && !mclr_i)
      |=> (day_units_o == $past(day_units_o) && month_o == $past(month_o)));

   p_month_end_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (day_tick_i && !any_set && !mclr_i && day_at_limit)
      |=> (day_tens_o == 2'd0 && day_units_o == 4'd1 && month_o != $past(month_o)));

   p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_i |=> (month_o == 4'd1 && !leap_o));

endmodule

// File: tb/cal_core_tb_top.sv
`timescale 1ns/1ps
module cal_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclr = 1'b0, tick = 1'b0, sd = 1'b0, sm = 1'b0, sw = 1'b0, lt = 1'b0;
   logic [1:0] day_tens;
   logic [3:0] day_units;
   logic [3:0] month;
   logic [2:0] wday;
   logic       leap;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   // reference model
   int m_day = 1, m_mon = 1, m_wday = 0;
   bit m_leap = 0;

   always #2.5 clk = ~clk;

   cal_core dut_i (
      .clk(clk), .rst_n(rst_n), .mclr_i(mclr), .day_tick_i(tick),
      .set_day_i(sd), .set_mon_i(sm), .set_wday_i(sw), .leap_tgl_i(lt),
      .day_tens_o(day_tens), .day_units_o(day_units), .month_o(month),
      .wday_o(wday), .leap_o(leap)
   );

   function automatic int mlen(int m, bit lp);
      if (m == 2) return lp ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic check(string req, string what, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   function automatic int dut_day();
      return int'(day_tens) * 10 + int'(day_units);
   endfunction

   task automatic check_model(string req);
      check(req, "day", dut_day(), m_day);
      check(req, "month", int'(month), m_mon);
      check(req, "weekday", int'(wday), m_wday);
      check(req, "leap", int'(leap), int'(m_leap));
   endtask

   task automatic model_update(bit c, bit t, bit d, bit mo, bit w, bit l);
      bit any_s, t_ok, d_step, mo_adv, w_step;
      int lim, n_day, n_mon, n_wday;
      bit n_leap;
      if (c) begin
         m_day = 1; m_mon = 1; m_wday = 0; m_leap = 0;
         return;
      end
      any_s  = d | mo | w;
      t_ok   = t & ~any_s;
      lim    = mlen(m_mon, m_leap);
      d_step = d | t_ok;
      mo_adv = mo | (t_ok & (m_day >= lim));
      w_step = w | t_ok;
      n_day  = d_step ? ((m_day >= lim) ? 1 : m_day + 1) : m_day;
      n_mon  = mo_adv ? ((m_mon == 12) ? 1 : m_mon + 1) : m_mon;
      n_leap = (mo_adv && m_mon == 12) ? 1'b0 : (l ? ~m_leap : m_leap);
      n_wday = w_step ? ((m_wday == 6) ? 0 : m_wday + 1) : m_wday;
      m_day = n_day; m_mon = n_mon; m_wday = n_wday; m_leap = n_leap;
   endtask

   // drive one cycle of inputs at a falling edge, sample at the next falling edge
   task automatic step(bit c, bit t, bit d, bit mo, bit w, bit l);
      mclr = c; tick = t; sd = d; sm = mo; sw = w; lt = l;
      @(negedge clk);
      mclr = 0; tick = 0; sd = 0; sm = 0; sw = 0; lt = 0;
      model_update(c, t, d, mo, w, l);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0);
   endtask

   task automatic go_to(int mo, int d, bit lp);
      step(1, 0, 0, 0, 0, 0);
      for (int i = 1; i < mo; i++) step(0, 0, 0, 1, 0, 0);
      if (lp) step(0, 0, 0, 0, 0, 1);
      for (int i = 1; i < d; i++) step(0, 0, 1, 0, 0, 0);
   endtask

   task automatic t_reset();
      check("R1", "reset day", dut_day(), 1);
      check("R1", "reset month", int'(month), 1);
      check("R1", "reset weekday", int'(wday), 0);
      check("R1", "reset leap", int'(leap), 0);
   endtask

   task automatic t_bcd_carry();
      ticks(8);
      check("R2", "day 9 units", int'(day_units), 9);
      ticks(1);
      check("R2", "9->10 tens", int'(day_tens), 1);
      check("R2", "9->10 units", int'(day_units), 0);
      ticks(10);
      check("R2", "19->20 tens", int'(day_tens), 2);
      check_model("R2");
   endtask

   task automatic t_month_lengths();
      // January: 31 days then carry
      go_to(1, 30, 0);
      ticks(1);
      check("R4", "jan day 31", dut_day(), 31);
      ticks(1);
      check("R3", "jan wrap day", dut_day(), 1);
      check("R3", "jan wrap month", int'(month), 2);
      // February without leap: 28 days
      ticks(27);
      check("R4", "feb day 28", dut_day(), 28);
      ticks(1);
      check("R4", "feb plain wrap month", int'(month), 3);
      check_model("R4");
      // February with leap: 29 days
      go_to(2, 28, 1);
      ticks(1);
      check("R4", "leap feb day 29", dut_day(), 29);
      ticks(1);
      check("R4", "leap feb wrap month", int'(month), 3);
      // 30-day month
      go_to(9, 30, 0);
      ticks(1);
      check("R4", "sep wrap day", dut_day(), 1);
      check("R4", "sep wrap month", int'(month), 10);
      // 31-day month August
      go_to(8, 30, 0);
      ticks(1);
      check("R4", "aug day 31", dut_day(), 31);
      check_model("R4");
   endtask

   task automatic t_over_limit();
      go_to(1, 31, 0);
      step(0, 0, 0, 1, 0, 0);
      check("R8", "set month keeps day 31", dut_day(), 31);
      check("R8", "set month month", int'(month), 2);
      ticks(1);
      check("R3", "over-limit wrap day", dut_day(), 1);
      check("R3", "over-limit wrap month", int'(month), 3);
      check_model("R3");
   endtask

   task automatic t_year_end();
      go_to(12, 31, 1);
      check("R6", "leap shown", int'(leap), 1);
      ticks(1);
      check("R5", "dec wrap month", int'(month), 1);
      check("R5", "dec wrap leap clear", int'(leap), 0);
      check("R5", "dec wrap day", dut_day(), 1);
      // toggle and manual year wrap in the same cycle: clear wins
      go_to(12, 5, 1);
      step(0, 0, 0, 1, 0, 1);
      check("R6", "toggle vs year clear", int'(leap), 0);
      check("R5", "manual wrap month", int'(month), 1);
      step(0, 0, 0, 0, 0, 1);
      check("R6", "toggle on", int'(leap), 1);
      step(0, 0, 0, 0, 0, 1);
      check("R6", "toggle off", int'(leap), 0);
      check_model("R6");
   endtask

   task automatic t_set_day();
      go_to(4, 30, 0);
      step(0, 0, 1, 0, 0, 0);
      check("R7", "set-day wrap day", dut_day(), 1);
      check("R7", "set-day wrap month", int'(month), 4);
      check_model("R7");
   endtask

   task automatic t_weekday();
      step(1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0);
      check("R9", "weekday 6", int'(wday), 6);
      check("R9", "set-weekday keeps day", dut_day(), 1);
      step(0, 0, 0, 0, 1, 0);
      check("R9", "weekday wrap", int'(wday), 0);
      ticks(3);
      check("R9", "tick steps weekday", int'(wday), 3);
      check_model("R9");
   endtask

   task automatic t_priority();
      go_to(3, 10, 0);
      step(0, 0, 0, 0, 1, 0);
      step(0, 1, 0, 1, 0, 0);
      check("R10", "tick+set-month day", dut_day(), 10);
      check("R10", "tick+set-month weekday", int'(wday), 1);
      check("R10", "tick+set-month month", int'(month), 4);
      step(0, 1, 0, 0, 1, 0);
      check("R10", "tick+set-weekday day", dut_day(), 10);
      check("R10", "tick+set-weekday weekday", int'(wday), 2);
      step(0, 1, 1, 0, 0, 0);
      check("R10", "tick+set-day day", dut_day(), 11);
      check("R10", "tick+set-day weekday", int'(wday), 2);
      check_model("R10");
   endtask

   task automatic t_mclr();
      go_to(7, 20, 1);
      step(0, 0, 0, 0, 1, 0);
      step(1, 1, 1, 1, 1, 1);
      check("R11", "clear day", dut_day(), 1);
      check("R11", "clear month", int'(month), 1);
      check("R11", "clear weekday", int'(wday), 0);
      check("R11", "clear leap", int'(leap), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bcd_carry();
      t_month_lengths();
      t_over_limit();
      t_year_end();
      t_set_day();
      t_weekday();
      t_priority();
      t_mclr();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule